// File: doc/BRIEF.md
# Single-Direction Peripheral Transfer Channel

This block moves bytes between one serial peripheral and system memory without processor involvement. Software loads a start address and a byte count through a small register window, and the channel then waits for the peripheral to request service. Each request produces exactly one memory access through a valid/ready master port. After the access the channel moves its address forward by one, lowers its remaining count by one and acknowledges the peripheral.

A build-time parameter fixes the direction. A receive channel writes the byte that the peripheral offered into memory. A transmit channel reads a byte from memory and hands it to the peripheral. When the remaining count is zero the channel is idle and reports a completion flag. An enable bit gates that flag onto an interrupt line.

Top module: `dtc_channel`

## Requirements
- R1: After reset the address is 0, the count is 0, the completion flag reads 1, the interrupt enable is 0, and `memValid`, `perAck` and `irq` are low.
- R2: Register window, selected by `regAddr`: 0 is the address (read/write, full width); 1 is the count (read/write, low 16 bits, upper bits read 0); 2 is status (bit 0 is the completion flag, read only); 3 is interrupt enable (bit 0, read/write). A write takes effect at the clock edge where `regWrEn` is high.
- R3: A request with a nonzero count raises `memValid` in the next cycle with `memAddr` equal to the current address. In a receive channel (`IS_TX`=0) `memWrite` is 1 and `memWData` carries the `perRxData` byte sampled with the request. In a transmit channel `memWrite` is 0.
- R4: While `memValid` is high and `memReady` is low, `memValid`, `memAddr` and `memWData` stay unchanged.
- R5: Each access that completes (`memValid` and `memReady` both high at a clock edge) raises the address by one, wrapping at the top of the address width, and lowers the count by one.
- R6: `perAck` is high for exactly the one cycle after a completed access. In a transmit channel, `perTxData` holds the byte read in that access from that cycle onward.
- R7: While the count is zero, requests are ignored: `memValid` stays low and the address does not move.
- R8: The completion flag equals "count is zero". It clears when a nonzero count is written, sets when the last access completes, and stays set when zero is written.
- R9: `irq` is high exactly when the completion flag and the interrupt enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational on `regAddr`) |
| perReq | input | 1 | Peripheral service request (level) |
| perAck | output | 1 | One-cycle acknowledge to the peripheral |
| perRxData | input | DATA_W | Byte offered by the peripheral (receive) |
| perTxData | output | DATA_W | Byte delivered to the peripheral (transmit) |
| memValid | output | 1 | Memory access request |
| memReady | input | 1 | Memory accepts the access |
| memWrite | output | 1 | 1 for a write access, 0 for a read access |
| memAddr | output | ADDR_W | Memory byte address |
| memWData | output | DATA_W | Write data |
| memRData | input | DATA_W | Read data, valid while `memReady` is high |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume that the peripheral keeps `perReq` high until it sees `perAck` and then lowers it. They also assume that `memRData` is valid in the cycle where `memReady` completes a read. The bench drives the peripheral side through a task that drops the request on the acknowledge. Its memory model answers combinationally from the address and varies `memReady` over a cyclic pattern, so that stall lengths differ between accesses. Register writes happen only while no access is in flight. This means the assertions never see a count or address change in the middle of a transfer.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

  localparam int REG_AW    = 2;
  localparam int REG_W     = 32;

  localparam logic [REG_AW-1:0] SEL_ADDR  = 2'd0;
  localparam logic [REG_AW-1:0] SEL_COUNT = 2'd1;
  localparam logic [REG_AW-1:0] SEL_STAT  = 2'd2;
  localparam logic [REG_AW-1:0] SEL_IRQEN = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_ACK  = 2'd2
  } dtcState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic captureRx;  // sample peripheral byte with an accepted request
    logic latchTx;    // sample memory read byte on a completed access
    logic step;       // advance address, lower count
  } dtcStrobes_t;

endpackage

// File: rtl/dtc_datapath.sv
module dtc_datapath
  import dtc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  input  dtcStrobes_t        strobes,
  input  logic [DATA_W-1:0]  perRxData,
  input  logic [DATA_W-1:0]  memRData,
  output logic [ADDR_W-1:0]  curAddr,
  output logic [DATA_W-1:0]  dataHold,
  output logic               countZero,
  output logic               irq
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = 1;
  localparam logic [CNT_W-1:0]  CNT_ONE  = 1;

  logic [CNT_W-1:0] count;
  logic             irqEnable;

  logic wrAddr, wrCount, wrIrqEn;
  assign wrAddr  = regWrEn && (regAddr == SEL_ADDR);
  assign wrCount = regWrEn && (regAddr == SEL_COUNT);
  assign wrIrqEn = regWrEn && (regAddr == SEL_IRQEN);

  // a register write wins over a transfer step in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
    end else if (wrAddr) begin
      curAddr <= regWrData[ADDR_W-1:0];
    end else if (strobes.step) begin
      curAddr <= curAddr + ADDR_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (wrCount) begin
      count <= regWrData[CNT_W-1:0];
    end else if (strobes.step) begin
      count <= count - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEnable <= 1'b0;
    end else if (wrIrqEn) begin
      irqEnable <= regWrData[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataHold <= '0;
    end else if (strobes.captureRx) begin
      dataHold <= perRxData;
    end else if (strobes.latchTx) begin
      dataHold <= memRData;
    end
  end

  assign countZero = (count == '0);
  assign irq       = countZero && irqEnable;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      SEL_ADDR:  regRdData[ADDR_W-1:0] = curAddr;
      SEL_COUNT: regRdData[CNT_W-1:0]  = count;
      SEL_STAT:  regRdData[0]          = countZero;
      SEL_IRQEN: regRdData[0]          = irqEnable;
      default:   regRdData             = '0;
    endcase
  end

endmodule

// File: rtl/dtc_control.sv
module dtc_control
  import dtc_pkg::*;
#(
  parameter bit IS_TX = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        perReq,
  input  logic        countZero,
  input  logic        memReady,
  output logic        memValid,
  output logic        perAck,
  output dtcStrobes_t strobes
);

  dtcState_t state, stateNext;

  logic startXfer, doneXfer;
  assign startXfer = (state == ST_IDLE) && perReq && !countZero;
  assign doneXfer  = (state == ST_BUSY) && memReady;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (startXfer) stateNext = ST_BUSY;
      ST_BUSY: if (memReady)  stateNext = ST_ACK;
      ST_ACK:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign memValid = (state == ST_BUSY);
  assign perAck   = (state == ST_ACK);

  always_comb begin
    strobes           = '0;
    strobes.captureRx = startXfer && !IS_TX;
    strobes.latchTx   = doneXfer && IS_TX;
    strobes.step      = doneXfer;
  end

endmodule

// File: rtl/dtc_channel.sv
module dtc_channel
  import dtc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter bit IS_TX  = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              perReq,
  output logic              perAck,
  input  logic [DATA_W-1:0] perRxData,
  output logic [DATA_W-1:0] perTxData,
  output logic              memValid,
  input  logic              memReady,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  input  logic [DATA_W-1:0] memRData,
  output logic              irq
);

  dtcStrobes_t       strobes;
  logic              countZero;
  logic [DATA_W-1:0] dataHold;

  dtc_control #(.IS_TX(IS_TX)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .perReq    (perReq),
    .countZero (countZero),
    .memReady  (memReady),
    .memValid  (memValid),
    .perAck    (perAck),
    .strobes   (strobes)
  );

  dtc_datapath #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .strobes   (strobes),
    .perRxData (perRxData),
    .memRData  (memRData),
    .curAddr   (memAddr),
    .dataHold  (dataHold),
    .countZero (countZero),
    .irq       (irq)
  );

  assign memWrite  = !IS_TX;
  assign memWData  = dataHold;
  assign perTxData = dataHold;

endmodule

// File: rtl/dtc_channel_chk.sv
module dtc_channel_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8,
  parameter bit IS_TX  = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic              perReq,
  input logic              perAck,
  input logic              memValid,
  input logic              memReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWData,
  input logic [DATA_W-1:0] memRData,
  input logic [DATA_W-1:0] perTxData
);

  // R3: an access only starts after a request
  assert_start_needs_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memValid) |-> $past(perReq));

  // R4: a stalled access holds its request and payload
  assert_hold_on_stall_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memWData)));

  // R6: acknowledge follows a completed access
  assert_ack_after_xfer_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady) |=> perAck);

  // R6: acknowledge lasts one cycle
  assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    perAck |=> !perAck);

  // R6: transmit byte is the byte read in the completed access
  assert_tx_byte_R6: assert property (@(posedge clk) disable iff (!rstN)
    (IS_TX && perAck) |-> (perTxData == $past(memRData)));

endmodule

bind dtc_channel dtc_channel_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .IS_TX  (IS_TX)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .perReq    (perReq),
  .perAck    (perAck),
  .memValid  (memValid),
  .memReady  (memReady),
  .memAddr   (memAddr),
  .memWData  (memWData),
  .memRData  (memRData),
  .perTxData (perTxData)
);

// File: tb/dtc_channel_tb.sv
module dtc_channel_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic        regWrEn   [2];
  logic [1:0]  regAddr   [2];
  logic [31:0] regWrData [2];
  logic [31:0] regRdData [2];
  logic        perReq    [2];
  logic        perAck    [2];
  logic [7:0]  perRxData [2];
  logic [7:0]  perTxData [2];
  logic        memValid  [2];
  logic        memReady  [2];
  logic        memWrite  [2];
  logic [31:0] memAddr   [2];
  logic [7:0]  memWData  [2];
  logic [7:0]  memRData  [2];
  logic        irq       [2];

  // channel 0: receive, channel 1: transmit
  dtc_channel #(.IS_TX(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn[0]), .regAddr(regAddr[0]),
    .regWrData(regWrData[0]), .regRdData(regRdData[0]), .perReq(perReq[0]),
    .perAck(perAck[0]), .perRxData(perRxData[0]), .perTxData(perTxData[0]),
    .memValid(memValid[0]), .memReady(memReady[0]), .memWrite(memWrite[0]),
    .memAddr(memAddr[0]), .memWData(memWData[0]), .memRData(memRData[0]),
    .irq(irq[0]));

  dtc_channel #(.IS_TX(1'b1)) u_dutTx (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn[1]), .regAddr(regAddr[1]),
    .regWrData(regWrData[1]), .regRdData(regRdData[1]), .perReq(perReq[1]),
    .perAck(perAck[1]), .perRxData(perRxData[1]), .perTxData(perTxData[1]),
    .memValid(memValid[1]), .memReady(memReady[1]), .memWrite(memWrite[1]),
    .memAddr(memAddr[1]), .memWData(memWData[1]), .memRData(memRData[1]),
    .irq(irq[1]));

  // memory model: read data derived from address, ready on a cyclic pattern
  assign memRData[0] = memAddr[0][7:0] ^ 8'h5A;
  assign memRData[1] = memAddr[1][7:0] ^ 8'h5A;

  int cyc = 0;
  always @(posedge clk) begin
    #2;
    cyc = cyc + 1;
    memReady[0] = (cyc % 3) == 0;
    memReady[1] = (cyc % 4) != 1;
  end

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard queues
  logic [39:0] rxQ[$];
  logic [7:0]  txQ[$];
  logic [31:0] ptrModel [2];
  logic [39:0] rxItem;
  logic [7:0]  txItem;

  // monitor: receive-side memory writes, transmit-side deliveries
  always @(negedge clk) begin
    if (rstN && memValid[0] && memReady[0]) begin
      if (rxQ.size() == 0) chk(1'b0, "R3 unexpected rx access", memAddr[0], 32'h0);
      else begin
        rxItem = rxQ.pop_front();
        chk(memAddr[0] == rxItem[39:8], "R3 rx address", memAddr[0], rxItem[39:8]);
        chk(memWData[0] == rxItem[7:0], "R3 rx write byte", {24'h0, memWData[0]}, {24'h0, rxItem[7:0]});
        chk(memWrite[0] == 1'b1, "R3 rx is write", {31'h0, memWrite[0]}, 32'h1);
      end
    end
    if (rstN && perAck[1]) begin
      if (txQ.size() == 0) chk(1'b0, "R6 unexpected tx ack", 32'h0, 32'h0);
      else begin
        txItem = txQ.pop_front();
        chk(perTxData[1] == txItem, "R6 tx byte", {24'h0, perTxData[1]}, {24'h0, txItem});
      end
    end
  end

  task automatic wrReg(input int i, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn[i] = 1'b1; regAddr[i] = a; regWrData[i] = d;
    @(negedge clk);
    regWrEn[i] = 1'b0;
  endtask

  task automatic rdReg(input int i, input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr[i] = a;
    #1 v = regRdData[i];
  endtask

  // one peripheral transfer; pushes the expected result, then runs the request
  task automatic xfer(input int i, input logic [7:0] b);
    logic [31:0] stallAddr;
    if (i == 0) rxQ.push_back({ptrModel[0], b});
    else        txQ.push_back(ptrModel[1][7:0] ^ 8'h5A);
    @(negedge clk);
    perReq[i] = 1'b1; perRxData[i] = b;
    @(negedge clk);
    chk(memValid[i] == 1'b1, "R3 valid one cycle after request", {31'h0, memValid[i]}, 32'h1);
    chk(memAddr[i] == ptrModel[i], "R3 address on request", memAddr[i], ptrModel[i]);
    if (i == 1) chk(memWrite[1] == 1'b0, "R3 tx is read", {31'h0, memWrite[1]}, 32'h0);
    stallAddr = memAddr[i];
    while (!perAck[i]) begin
      if (memValid[i]) chk(memAddr[i] == stallAddr, "R4 address held", memAddr[i], stallAddr);
      @(negedge clk);
    end
    perReq[i] = 1'b0;
    @(negedge clk);
    chk(perAck[i] == 1'b0, "R6 ack single cycle", {31'h0, perAck[i]}, 32'h0);
    ptrModel[i] = ptrModel[i] + 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nErrors++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 2; i++) begin
      regWrEn[i] = 0; regAddr[i] = 0; regWrData[i] = 0;
      perReq[i] = 0; perRxData[i] = 0; memReady[i] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdReg(0, 2'd0, v); chk(v == 0, "R1 address after reset", v, 0);
    rdReg(0, 2'd1, v); chk(v == 0, "R1 count after reset", v, 0);
    rdReg(0, 2'd2, v); chk(v == 1, "R1 flag after reset", v, 1);
    rdReg(0, 2'd3, v); chk(v == 0, "R1 irq enable after reset", v, 0);
    chk(!memValid[0] && !perAck[0] && !irq[0], "R1 outputs low after reset",
        {29'h0, memValid[0], perAck[0], irq[0]}, 0);

    // receive channel: R2 programming
    wrReg(0, 2'd0, 32'h0000_1000);
    wrReg(0, 2'd1, 32'hABCD_0003);
    rdReg(0, 2'd1, v); chk(v == 32'h3, "R2 count low bits only", v, 32'h3);
    rdReg(0, 2'd0, v); chk(v == 32'h1000, "R2 address readback", v, 32'h1000);
    rdReg(0, 2'd2, v); chk(v == 0, "R8 flag clears on nonzero count", v, 0);
    wrReg(0, 2'd3, 32'h1);
    #1 chk(irq[0] == 1'b0, "R9 irq low while count nonzero", {31'h0, irq[0]}, 0);
    ptrModel[0] = 32'h1000;
    xfer(0, 8'h3C);
    rdReg(0, 2'd1, v); chk(v == 32'h2, "R5 count after one access", v, 32'h2);
    xfer(0, 8'hC5);
    xfer(0, 8'h01);
    rdReg(0, 2'd0, v); chk(v == 32'h1003, "R5 address after three", v, 32'h1003);
    rdReg(0, 2'd1, v); chk(v == 0, "R5 count after three", v, 0);
    rdReg(0, 2'd2, v); chk(v == 1, "R8 flag set at end", v, 1);
    chk(irq[0] == 1'b1, "R9 irq at end with enable", {31'h0, irq[0]}, 1);

    // R7: requests ignored with zero count
    @(negedge clk); perReq[0] = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(memValid[0] == 1'b0, "R7 no access at zero count", {31'h0, memValid[0]}, 0);
    end
    perReq[0] = 1'b0;
    rdReg(0, 2'd0, v); chk(v == 32'h1003, "R7 address unmoved", v, 32'h1003);
    wrReg(0, 2'd1, 32'h0);
    rdReg(0, 2'd2, v); chk(v == 1, "R8 flag stays set on zero write", v, 1);
    wrReg(0, 2'd3, 32'h0);
    #1 chk(irq[0] == 1'b0, "R9 irq off when disabled", {31'h0, irq[0]}, 0);

    // transmit channel with address wrap
    wrReg(1, 2'd0, 32'hFFFF_FFFE);
    wrReg(1, 2'd1, 32'h2);
    ptrModel[1] = 32'hFFFF_FFFE;
    xfer(1, 8'h00);
    xfer(1, 8'h00);
    rdReg(1, 2'd0, v); chk(v == 32'h0, "R5 address wraps", v, 0);
    rdReg(1, 2'd2, v); chk(v == 1, "R8 tx flag at end", v, 1);
    chk(perTxData[1] == (8'hFF ^ 8'h5A), "R6 tx byte held after ack",
        {24'h0, perTxData[1]}, {24'h0, 8'hFF ^ 8'h5A});
    chk(rxQ.size() == 0 && txQ.size() == 0, "R3 scoreboard drained",
        rxQ.size() + txQ.size(), 0);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule